// File: doc/BRIEF.md
# Two-Core Cache Way Split Tuner

This block decides how the sixteen allocation units of a shared cache are divided between two cores. After a start pulse it begins with an even split. It measures the combined miss count of both cores over one epoch, and then measures each neighbouring split for one epoch. Those neighbours give core 0 one unit more or one unit less. The block then moves to whichever of the three candidates missed least. It repeats this search until the finish input is seen at a decision point. It then stops and holds the chosen split.

The cache uses the two quota outputs to mask ways. The phase output tells the environment which candidate is being measured at the moment. Miss events arrive as one-bit strobes, one per core per cycle. An epoch ends on any cycle in which `epoch_end` is high.

Top module: `wpc_way_split`

## Requirements
- R1: After reset, `quota_c0` and `quota_c1` are both 8, `busy` and `done` are 0, and `phase` is 0.
- R2: A cycle with `start` high makes the next cycle show `busy`=1, `done`=0, `phase`=0 (baseline) and quota 8/8, and clears the miss tally.
- R3: In every cycle `quota_c1` equals 16 minus `quota_c0`.
- R4: The metric of an epoch is the number of cycles with `miss_c0` high plus the number with `miss_c1` high. It covers every cycle from the first cycle of the epoch through the `epoch_end` cycle. The tally is CNT_W bits wide (32 by default) and sticks at all-ones instead of wrapping.
- R5: Phase codes are 0 baseline, 1 trial with core 0 at base+1, 2 trial with core 0 at base-1, and 3 decide. Each `epoch_end` while busy advances 0→1→2→3. Decide lasts one cycle, after which phase 0 resumes with the new base.
- R6: A trial that would leave either core with fewer than 1 unit is skipped. With base 15, phase goes 0→2. With base 1, phase goes 0→1→3.
- R7: Decide adopts the candidate with the strictly lowest metric. On a tie with the baseline, the base is kept. On a tie between the two trials, the +1 trial wins.
- R8: If `finish` is high in the decide cycle, the new split is adopted, `busy` drops to 0 and `done` rises to 1. The quotas then hold until the next start.
- R9: While `busy` is 0, `epoch_end` and miss strobes have no effect on any output.
- R10: A start pulse in the middle of a search restarts it from 8/8 in phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin (or restart) the search from an even split |
| finish | input | 1 | Stop at the next decision point |
| epoch_end | input | 1 | Last cycle of the current epoch |
| miss_c0 | input | 1 | One miss by core 0 in this cycle |
| miss_c1 | input | 1 | One miss by core 1 in this cycle |
| quota_c0 | output | 5 | Units granted to core 0 |
| quota_c1 | output | 5 | Units granted to core 1 |
| phase | output | 2 | 0 baseline, 1 plus trial, 2 minus trial, 3 decide |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search ended, split held |

## Verification
The assertions assume that `start` is a single-cycle pulse and that the inputs are synchronous and free of X once reset has been released. The stimulus drives every input on the falling edge. It pulses start for exactly one cycle. It sends miss counts whose size depends on the distance from a target split, so the search steers deliberately into both edge splits. One test uses a narrow tally so that saturation can change the outcome of a decision.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    PH_BASE   = 2'd0,
    PH_UP     = 2'd1,
    PH_DN     = 2'd2,
    PH_DECIDE = 2'd3
  } wpc_phase_e;
endpackage

// File: rtl/wpc_miss_tally.sv
module wpc_miss_tally #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit_a,
  input  logic             hit_b,
  output logic [CNT_W-1:0] metric
);
  localparam logic [CNT_W:0] CAP = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum    = {1'b0, cnt_q} + (CNT_W+1)'(hit_a) + (CNT_W+1)'(hit_b);
    metric = (sum > CAP) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    cnt_d  = clr ? '0 : metric;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TALLY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CNT_W{1'b1}} && !clr) |=> (cnt_q == {CNT_W{1'b1}})); // R4
  AST_TALLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/wpc_split_pick.sv
module wpc_split_pick #(
  parameter int QW    = 5,
  parameter int CNT_W = 32
) (
  input  logic [QW-1:0]    base,
  input  logic [CNT_W-1:0] m_base,
  input  logic [CNT_W-1:0] m_up,
  input  logic [CNT_W-1:0] m_dn,
  input  logic             up_ok,
  input  logic             dn_ok,
  output logic [QW-1:0]    next_base
);
  logic [CNT_W-1:0] best_m;

  always_comb begin
    next_base = base;
    best_m    = m_base;
    if (up_ok && (m_up < best_m)) begin
      next_base = base + QW'(1);
      best_m    = m_up;
    end
    if (dn_ok && (m_dn < best_m)) begin
      next_base = base - QW'(1);
      best_m    = m_dn;
    end
  end
endmodule

// File: rtl/wpc_way_split.sv
module wpc_way_split
  import wpc_pkg::*;
#(
  parameter int UNITS = 16,
  parameter int CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       finish,
  input  logic                       epoch_end,
  input  logic                       miss_c0,
  input  logic                       miss_c1,
  output logic [$clog2(UNITS+1)-1:0] quota_c0,
  output logic [$clog2(UNITS+1)-1:0] quota_c1,
  output logic [1:0]                 phase,
  output logic                       busy,
  output logic                       done
);
  localparam int QW = $clog2(UNITS+1);
  localparam logic [QW-1:0] HALF = QW'(UNITS/2);
  localparam logic [QW-1:0] TOP  = QW'(UNITS-1);

  wpc_phase_e       phase_q, phase_d;
  logic             busy_q, busy_d, done_q, done_d;
  logic [QW-1:0]    base_q, base_d, pick;
  logic [CNT_W-1:0] mb_q, mu_q, md_q, metric;
  logic             mb_en, mu_en, md_en;
  logic             up_ok, dn_ok, clr;

  assign up_ok = (base_q < TOP);
  assign dn_ok = (base_q > QW'(1));
  assign clr   = start | ~busy_q | (phase_q == PH_DECIDE) | epoch_end;

  wpc_miss_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .hit_a(miss_c0), .hit_b(miss_c1), .metric(metric)
  );

  wpc_split_pick #(.QW(QW), .CNT_W(CNT_W)) u_pick (
    .base(base_q), .m_base(mb_q), .m_up(mu_q), .m_dn(md_q),
    .up_ok(up_ok), .dn_ok(dn_ok), .next_base(pick)
  );

  always_comb begin
    phase_d = phase_q;
    busy_d  = busy_q;
    done_d  = done_q;
    base_d  = base_q;
    mb_en   = 1'b0;
    mu_en   = 1'b0;
    md_en   = 1'b0;
    if (start) begin
      phase_d = PH_BASE;
      busy_d  = 1'b1;
      done_d  = 1'b0;
      base_d  = HALF;
    end else if (busy_q) begin
      case (phase_q)
        PH_BASE: if (epoch_end) begin
          mb_en   = 1'b1;
          phase_d = up_ok ? PH_UP : (dn_ok ? PH_DN : PH_DECIDE);
        end
        PH_UP: if (epoch_end) begin
          mu_en   = 1'b1;
          phase_d = dn_ok ? PH_DN : PH_DECIDE;
        end
        PH_DN: if (epoch_end) begin
          md_en   = 1'b1;
          phase_d = PH_DECIDE;
        end
        default: begin
          base_d  = pick;
          phase_d = PH_BASE;
          if (finish) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_BASE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      base_q  <= HALF;
    end else begin
      phase_q <= phase_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      base_q  <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_q <= '0;
      mu_q <= '0;
      md_q <= '0;
    end else begin
      if (mb_en) mb_q <= metric;
      if (mu_en) mu_q <= metric;
      if (md_en) md_q <= metric;
    end
  end

  always_comb begin
    case (phase_q)
      PH_UP:   quota_c0 = base_q + QW'(1);
      PH_DN:   quota_c0 = base_q - QW'(1);
      default: quota_c0 = base_q;
    endcase
    quota_c1 = QW'(UNITS) - quota_c0;
  end

  assign phase = phase_q;
  assign busy  = busy_q;
  assign done  = done_q;

  AST_QUOTA_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (quota_c0 >= QW'(1)) && (quota_c1 >= QW'(1))); // R6
  AST_DECIDE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3) |=> (phase != 2'd3)); // R5
  AST_START_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && phase == 2'd0 && quota_c0 == HALF)); // R10
  AST_TRIAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && phase == 2'd0 && epoch_end) |=>
      ((phase == 2'd1 && quota_c0 == $past(quota_c0) + QW'(1)) ||
       (phase == 2'd2 && quota_c0 == $past(quota_c0) - QW'(1)) ||
       (phase == 2'd3))); // R5
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && !busy && $stable(quota_c0))); // R8
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!busy && $stable(quota_c0) && $stable(phase))); // R9
endmodule

// File: tb/wpc_way_split_tb.sv
module wpc_way_split_tb;
  localparam int UNITS = 16;
  localparam int CW    = 8;
  localparam int MAXC  = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, finish = 1'b0, epoch_end = 1'b0;
  logic       miss_c0 = 1'b0, miss_c1 = 1'b0;
  logic [4:0] quota_c0, quota_c1;
  logic [1:0] phase;
  logic       busy, done;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;

  // behavioural reference state
  int  rm_phase, rm_base, rm_cnt, rm_mb, rm_mu, rm_md;
  bit  rm_busy, rm_done;

  always #10 clk = ~clk;

  wpc_way_split #(.UNITS(UNITS), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .finish(finish),
    .epoch_end(epoch_end), .miss_c0(miss_c0), .miss_c1(miss_c1),
    .quota_c0(quota_c0), .quota_c1(quota_c1), .phase(phase),
    .busy(busy), .done(done)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int rm_quota();
    if (rm_phase == 1) return rm_base + 1;
    if (rm_phase == 2) return rm_base - 1;
    return rm_base;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rm_phase = 0; rm_base = 8; rm_cnt = 0; rm_busy = 0; rm_done = 0;
      rm_mb = 0; rm_mu = 0; rm_md = 0;
    end else if (start) begin
      rm_phase = 0; rm_base = 8; rm_cnt = 0; rm_busy = 1; rm_done = 0;
    end else if (!rm_busy) begin
      rm_cnt = 0;
    end else if (rm_phase == 3) begin
      int best, bm;
      best = rm_base; bm = rm_mb;
      if (rm_base < UNITS - 1 && rm_mu < bm) begin best = rm_base + 1; bm = rm_mu; end
      if (rm_base > 1 && rm_md < bm) best = rm_base - 1;
      rm_base = best; rm_phase = 0; rm_cnt = 0;
      if (finish) begin rm_busy = 0; rm_done = 1; end
    end else begin
      int m;
      m = rm_cnt + int'(miss_c0) + int'(miss_c1);
      if (m > MAXC) m = MAXC;
      if (epoch_end) begin
        rm_cnt = 0;
        if (rm_phase == 0) begin
          rm_mb = m;
          rm_phase = (rm_base < UNITS - 1) ? 1 : ((rm_base > 1) ? 2 : 3);
        end else if (rm_phase == 1) begin
          rm_mu = m;
          rm_phase = (rm_base > 1) ? 2 : 3;
        end else begin
          rm_md = m;
          rm_phase = 3;
        end
      end else rm_cnt = m;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk(int'(quota_c0) == rm_quota(), "R5", "quota_c0", int'(quota_c0), rm_quota());
      chk(int'(quota_c1) == UNITS - int'(quota_c0), "R3", "quota_c1", int'(quota_c1), UNITS - int'(quota_c0));
      chk(int'(phase) == rm_phase, "R5", "phase", int'(phase), rm_phase);
      chk(busy == rm_busy, "R8", "busy", int'(busy), int'(rm_busy));
      chk(done == rm_done, "R8", "done", int'(done), int'(rm_done));
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic epoch_raw(int len, int n0, int n1);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      miss_c0 = (i < n0); miss_c1 = (i < n1); epoch_end = (i == len - 1);
    end
    @(negedge clk);
    miss_c0 = 1'b0; miss_c1 = 1'b0; epoch_end = 1'b0;
  endtask

  task automatic run_round(int target, bit flat);
    do begin
      int d;
      d = int'(quota_c0) - target;
      if (d < 0) d = -d;
      d = flat ? 0 : 3 * d;
      epoch_raw(50, d, d / 2);
    end while (phase != 2'd3 && busy);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(quota_c0 == 5'd8 && quota_c1 == 5'd8, "R1", "reset quotas c0", int'(quota_c0), 8);
    chk(!busy && !done && phase == 2'd0, "R1", "reset busy/done/phase", {busy, done, phase}, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R9: idle strobes do nothing
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); epoch_end = 1'b1; miss_c0 = 1'b1; miss_c1 = i[0];
    end
    @(negedge clk); epoch_end = 1'b0; miss_c0 = 1'b0; miss_c1 = 1'b0;
    @(negedge clk);
    chk(!busy && quota_c0 == 5'd8 && phase == 2'd0, "R9", "idle quota", int'(quota_c0), 8);

    // R2: start
    pulse_start();
    chk(busy && !done && phase == 2'd0 && quota_c0 == 5'd8, "R2", "start state", int'(quota_c0), 8);

    // R7/R6: climb to the upper edge
    for (int r = 0; r < 9; r++) run_round(15, 1'b0);
    chk(quota_c0 == 5'd15, "R6", "converged top", int'(quota_c0), 15);
    // R6: at base 15 the plus trial is skipped
    epoch_raw(20, 0, 0);
    chk(phase == 2'd2 && quota_c0 == 5'd14, "R6", "skip plus trial phase", int'(phase), 2);
    run_round(15, 1'b0);

    // R7/R6: descend to the lower edge
    for (int r = 0; r < 16; r++) run_round(1, 1'b0);
    chk(quota_c0 == 5'd1 && quota_c1 == 5'd15, "R6", "converged bottom", int'(quota_c0), 1);
    epoch_raw(20, 0, 0);
    chk(phase == 2'd1 && quota_c0 == 5'd2, "R6", "plus trial at base 1", int'(phase), 1);
    epoch_raw(20, 0, 0);
    chk(phase == 2'd3, "R6", "minus trial skipped at base 1", int'(phase), 3);
    @(negedge clk);

    // R7: all ties keep the base
    pulse_start();
    run_round(0, 1'b1);
    chk(quota_c0 == 5'd8, "R7", "tie keeps base", int'(quota_c0), 8);

    // R7: trial tie, plus wins
    epoch_raw(30, 20, 0);
    epoch_raw(30, 5, 0);
    epoch_raw(30, 5, 0);
    @(negedge clk);
    chk(quota_c0 == 5'd9, "R7", "trial tie picks plus", int'(quota_c0), 9);

    // R4: saturation decides the outcome (base 255 sticky, plus 150)
    pulse_start();
    epoch_raw(200, 200, 200);
    epoch_raw(200, 150, 0);
    epoch_raw(200, 200, 200);
    @(negedge clk);
    chk(quota_c0 == 5'd9, "R4", "saturated baseline loses", int'(quota_c0), 9);

    // R4: exact count including the epoch_end cycle
    pulse_start();
    epoch_raw(10, 10, 0);
    epoch_raw(10, 9, 0);
    epoch_raw(10, 10, 1);
    @(negedge clk);
    chk(quota_c0 == 5'd9, "R4", "end cycle counted", int'(quota_c0), 9);

    // R10: restart mid-search
    epoch_raw(20, 3, 3);
    chk(phase == 2'd1, "R10", "in plus trial before restart", int'(phase), 1);
    pulse_start();
    chk(quota_c0 == 5'd8 && phase == 2'd0 && busy, "R10", "restart to even", int'(quota_c0), 8);

    // R8: finish at decide
    finish = 1'b1;
    run_round(12, 1'b0);
    finish = 1'b0;
    chk(done && !busy && quota_c0 == 5'd9, "R8", "finished split", int'(quota_c0), 9);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk); epoch_end = 1'b1; miss_c0 = 1'b1; miss_c1 = 1'b1;
    end
    @(negedge clk); epoch_end = 1'b0; miss_c0 = 1'b0; miss_c1 = 1'b0;
    @(negedge clk);
    chk(done && quota_c0 == 5'd9 && phase == 2'd0, "R8", "held after done", int'(quota_c0), 9);
    chk(!busy, "R9", "no activity while stopped", int'(busy), 0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule